// File: doc/BRIEF.md
# Planar Write Data Path

This block forms the 32-bit word that a four-plane frame buffer stores when the host writes one byte. Each plane is one byte lane of the word. The host byte can be rotated right by a programmable amount. It is then expanded into four plane bytes by one of four write modes. A logic unit combines that expansion with a display latch. Finally, a per-bit selector picks between the logic result and the latch.

The display latch holds the last full word read from the frame buffer, so read-modify-write sequences take one read followed by one write. Mode, logic function, rotate count, set/reset, enable set/reset and bit mask are plain register inputs that are sampled on each write. The block accepts one write per cycle and presents each result one clock later. Address decoding and plane enables belong to the surrounding logic.

Top module: `planar_write_path`

## Requirements
- R1: While `rstN` is low, `outValid` is 0, `outWord` is 0 and the display latch is cleared to 0.
- R2: `outValid` is 1 in exactly the cycle after a cycle with `wrValid` high. `outWord` changes only on those cycles and otherwise holds its last value.
- R3: A cycle with `rdValid` high loads all 32 bits of `rdData` into the display latch. A write in that same cycle uses the latch value from before the load.
- R4: The rotated byte is `hostByte` rotated right by `rotCount` (0 to 7) positions. Write modes 0 and 3 use it; mode 2 uses the unrotated `hostByte`.
- R5: Write mode 0 (`writeMode`=0): plane b (bits 8b+7..8b of the word) is 8 copies of `setReset[b]` when `enSetReset[b]` is 1, and the rotated byte otherwise.
- R6: Write mode 1 (`writeMode`=1): `outWord` equals the display latch, whatever the host byte, logic function and bit mask.
- R7: Write mode 2 (`writeMode`=2): plane b is 8 copies of `hostByte[b]`.
- R8: Write mode 3 (`writeMode`=3): plane b is 8 copies of `setReset[b]`, and the effective mask is the rotated byte ANDed with `bitMask`.
- R9: The logic unit combines the mode output with the latch, encoded by `logicFn` as 0=COPY (mode output), 1=AND, 2=OR, 3=XOR.
- R10: Outside mode 1, bit n of every plane takes the logic unit output when effective-mask bit n is 1 and the latch bit when it is 0. The effective mask is `bitMask` in modes 0 and 2.
- R11: A `bitMask` of zero with COPY yields the display latch unchanged in every write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write byte present this cycle |
| hostByte | input | 8 | Host write data |
| rdValid | input | 1 | Frame buffer read word present this cycle |
| rdData | input | 32 | Word read from the frame buffer |
| rotCount | input | 3 | Right-rotate amount for the host byte |
| logicFn | input | 2 | Logic function: 0 COPY, 1 AND, 2 OR, 3 XOR |
| writeMode | input | 2 | Write mode 0..3 |
| setReset | input | 4 | Per-plane fill value |
| enSetReset | input | 4 | Per-plane fill enable for mode 0 |
| bitMask | input | 8 | Per-bit latch/result selector |
| outValid | output | 1 | Result word valid |
| outWord | output | 32 | Word to store into the four planes |

## Verification
On every cycle the assertions check the timing relation between a write and its result, the hold of the output between writes, and the latch load from a read. They also check the value-level rules that follow from the latch alone: mode 1 passes the latch through, and a zero mask with COPY yields the latch. Mode 2 with a full mask and COPY is checked against the replicated host nibble. Rotation amounts, the mode 0 mixing of set/reset and host data, the mode 3 mask formed from the rotated byte, and the three combining logic functions only show in the bench's scenarios, where a scoreboard compares each word with one computed from the requirements. The same-cycle read-and-write ordering is also shown only there.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  typedef enum logic [1:0] {
    WM_MIX    = 2'd0,
    WM_LATCH  = 2'd1,
    WM_NIBBLE = 2'd2,
    WM_FILL   = 2'd3
  } wrMode_e;

  typedef enum logic [1:0] {
    LF_COPY = 2'd0,
    LF_AND  = 2'd1,
    LF_OR   = 2'd2,
    LF_XOR  = 2'd3
  } logicFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLatch;    // capture read word into latch
    logic emit;         // register a new result word
    logic srcLatchOnly; // result is the latch itself
    logic srcNibble;    // planes from host low bits
    logic srcFill;      // planes from set/reset
    logic maskFromHost; // effective mask uses rotated byte
  } ctrlStrobe_t;

endpackage

// File: rtl/pwp_rotator.sv
module pwp_rotator #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] dIn,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] dOut
);

  // Right rotation: output bit i takes input bit (i + count) mod BYTE_W
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic [CNT_W:0] srcIdx;
    always_comb begin
      srcIdx = (CNT_W+1)'(i) + {1'b0, count};
      if (srcIdx >= (CNT_W+1)'(BYTE_W)) srcIdx = srcIdx - (CNT_W+1)'(BYTE_W);
      dOut[i] = dIn[srcIdx[CNT_W-1:0]];
    end
  end

endmodule

// File: rtl/pwp_ctrl.sv
module pwp_ctrl
  import pwp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        rdValid,
  input  logic [1:0]  writeMode,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  wrMode_e modeNow;

  always_comb begin
    modeNow             = wrMode_e'(writeMode);
    strobe              = '0;
    strobe.loadLatch    = rdValid;
    strobe.emit         = wrValid;
    unique case (modeNow)
      WM_MIX:    ;
      WM_LATCH:  strobe.srcLatchOnly = 1'b1;
      WM_NIBBLE: strobe.srcNibble    = 1'b1;
      WM_FILL: begin
        strobe.srcFill      = 1'b1;
        strobe.maskFromHost = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= wrValid;
  end

endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = PLANES * BYTE_W,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic [WORD_W-1:0] rdData,
  input  logic [CNT_W-1:0]  rotCount,
  input  logic [1:0]        logicFn,
  input  logic [PLANES-1:0] setReset,
  input  logic [PLANES-1:0] enSetReset,
  input  logic [BYTE_W-1:0] bitMask,
  output logic [WORD_W-1:0] outWord,
  output logic [WORD_W-1:0] latchWord
);

  logic [BYTE_W-1:0] rotByte;
  logic [BYTE_W-1:0] effMask;
  logic [WORD_W-1:0] modeWord;
  logic [WORD_W-1:0] aluWord;
  logic [WORD_W-1:0] mergedWord;
  logic [WORD_W-1:0] resultWord;

  pwp_rotator #(.BYTE_W(BYTE_W)) uRot (
    .dIn   (hostByte),
    .count (rotCount),
    .dOut  (rotByte)
  );

  assign effMask = strobe.maskFromHost ? (rotByte & bitMask) : bitMask;

  for (genvar b = 0; b < PLANES; b++) begin : g_plane
    logic [BYTE_W-1:0] srcByte;
    logic [BYTE_W-1:0] latByte;
    logic [BYTE_W-1:0] aluByte;

    assign latByte = latchWord[b*BYTE_W +: BYTE_W];

    always_comb begin
      if (strobe.srcFill)
        srcByte = {BYTE_W{setReset[b]}};
      else if (strobe.srcNibble)
        srcByte = {BYTE_W{hostByte[b]}};
      else if (enSetReset[b])
        srcByte = {BYTE_W{setReset[b]}};
      else
        srcByte = rotByte;
    end

    always_comb begin
      unique case (logicFn_e'(logicFn))
        LF_COPY: aluByte = srcByte;
        LF_AND:  aluByte = srcByte & latByte;
        LF_OR:   aluByte = srcByte | latByte;
        LF_XOR:  aluByte = srcByte ^ latByte;
        default: aluByte = srcByte;
      endcase
    end

    assign modeWord[b*BYTE_W +: BYTE_W]   = srcByte;
    assign aluWord[b*BYTE_W +: BYTE_W]    = aluByte;
    assign mergedWord[b*BYTE_W +: BYTE_W] = (aluByte & effMask) | (latByte & ~effMask);
  end

  assign resultWord = strobe.srcLatchOnly ? latchWord : mergedWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchWord <= '0;
      outWord   <= '0;
    end else begin
      if (strobe.emit)      outWord   <= resultWord;
      if (strobe.loadLatch) latchWord <= rdData;
    end
  end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
  import pwp_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = PLANES * BYTE_W,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [BYTE_W-1:0] hostByte,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  input  logic [CNT_W-1:0]  rotCount,
  input  logic [1:0]        logicFn,
  input  logic [1:0]        writeMode,
  input  logic [PLANES-1:0] setReset,
  input  logic [PLANES-1:0] enSetReset,
  input  logic [BYTE_W-1:0] bitMask,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);

  ctrlStrobe_t       strobe;
  logic [WORD_W-1:0] latchWord;

  pwp_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .rdValid   (rdValid),
    .writeMode (writeMode),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  pwp_datapath #(.PLANES(PLANES), .BYTE_W(BYTE_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostByte   (hostByte),
    .rdData     (rdData),
    .rotCount   (rotCount),
    .logicFn    (logicFn),
    .setReset   (setReset),
    .enSetReset (enSetReset),
    .bitMask    (bitMask),
    .outWord    (outWord),
    .latchWord  (latchWord)
  );

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = PLANES * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [BYTE_W-1:0] hostByte,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdData,
  input logic [1:0]        writeMode,
  input logic [1:0]        logicFn,
  input logic [BYTE_W-1:0] bitMask,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord,
  input logic [WORD_W-1:0] latchWord
);

  logic [WORD_W-1:0] nibbleWord;
  for (genvar b = 0; b < PLANES; b++) begin : g_nib
    assign nibbleWord[b*BYTE_W +: BYTE_W] = {BYTE_W{hostByte[b]}};
  end

  assert_valid_after_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> outValid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !outValid);

  assert_word_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(outWord));

  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> (latchWord == $past(rdData)));

  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> $stable(latchWord));

  assert_mode1_passes_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && writeMode == 2'd1) |=> (outWord == $past(latchWord)));

  assert_mode2_nibble_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && writeMode == 2'd2 && logicFn == 2'd0 && bitMask == {BYTE_W{1'b1}})
      |=> (outWord == $past(nibbleWord)));

  assert_zero_mask_copy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && bitMask == '0 && logicFn == 2'd0) |=> (outWord == $past(latchWord)));

endmodule

bind planar_write_path pwp_checker #(.PLANES(PLANES), .BYTE_W(BYTE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrValid   (wrValid),
  .hostByte  (hostByte),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .writeMode (writeMode),
  .logicFn   (logicFn),
  .bitMask   (bitMask),
  .outValid  (outValid),
  .outWord   (outWord),
  .latchWord (latchWord)
);

// File: tb/planar_write_path_test.sv
`timescale 1ns/1ps
module planar_write_path_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  hostByte = '0;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [2:0]  rotCount = '0;
  logic [1:0]  logicFn = '0;
  logic [1:0]  writeMode = '0;
  logic [3:0]  setReset = '0;
  logic [3:0]  enSetReset = '0;
  logic [7:0]  bitMask = '0;
  logic        outValid;
  logic [31:0] outWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] mLatch = '0;
  logic [31:0] lastExp = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #4 clk = ~clk;

  planar_write_path uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .hostByte(hostByte),
    .rdValid(rdValid), .rdData(rdData), .rotCount(rotCount), .logicFn(logicFn),
    .writeMode(writeMode), .setReset(setReset), .enSetReset(enSetReset),
    .bitMask(bitMask), .outValid(outValid), .outWord(outWord)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference computed from the requirement text
  function automatic logic [31:0] refWord(input logic [7:0] h, input logic [2:0] rc,
      input logic [1:0] lf, input logic [1:0] wm, input logic [3:0] sr,
      input logic [3:0] esr, input logic [7:0] bm, input logic [31:0] lat);
    logic [7:0]  rot;
    logic [7:0]  msk;
    logic [31:0] w;
    logic [31:0] f;
    logic [31:0] m32;
    rot = 8'((({h, h}) >> rc));
    if (wm == 2'd1) return lat;
    for (int b = 0; b < 4; b++) begin
      case (wm)
        2'd0: w[b*8 +: 8] = esr[b] ? {8{sr[b]}} : rot;
        2'd2: w[b*8 +: 8] = {8{h[b]}};
        default: w[b*8 +: 8] = {8{sr[b]}};
      endcase
    end
    case (lf)
      2'd0: f = w;
      2'd1: f = w & lat;
      2'd2: f = w | lat;
      default: f = w ^ lat;
    endcase
    msk = (wm == 2'd3) ? (rot & bm) : bm;
    m32 = {4{msk}};
    return (f & m32) | (lat & ~m32);
  endfunction

  // Driver: one cycle of stimulus, expected item pushed for writes
  task automatic drive(input bit wr, input bit rd, input logic [7:0] h, input logic [31:0] rdd,
      input logic [2:0] rc, input logic [1:0] lf, input logic [1:0] wm,
      input logic [3:0] sr, input logic [3:0] esr, input logic [7:0] bm, input string tag);
    item_t it;
    wrValid = wr; rdValid = rd; hostByte = h; rdData = rdd; rotCount = rc;
    logicFn = lf; writeMode = wm; setReset = sr; enSetReset = esr; bitMask = bm;
    if (wr) begin
      it.exp = refWord(h, rc, lf, wm, sr, esr, bm, mLatch);
      it.tag = tag;
      sbQ.push_back(it);
      lastExp = it.exp;
    end
    if (rd) mLatch = rdd;
    @(negedge clk);
    wrValid = 1'b0; rdValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R2 unexpected result", outWord, 32'h0);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        check(outWord == it.exp, it.tag, outWord, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 32'h0);
    check(outWord == 32'h0, "R1 outWord in reset", outWord, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // Latch cleared by reset: mode 1 write yields zero
    drive(1, 0, 8'hFF, 0, 0, 2'd0, 2'd1, 4'h0, 4'h0, 8'hFF, "R1 latch cleared");
    // Load latch, then pass through
    drive(0, 1, 8'h00, 32'hA5C3_3C5A, 0, 0, 0, 0, 0, 0, "");
    drive(1, 0, 8'h77, 0, 3'd5, 2'd3, 2'd1, 4'hF, 4'hF, 8'h0F, "R3/R6 latch pass");
    // Mode 0 host data, no rotation, COPY, full mask
    drive(1, 0, 8'h96, 0, 3'd0, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, "R5 host planes");
    // Rotation amounts
    drive(1, 0, 8'h81, 0, 3'd3, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, "R4 rotate 3");
    drive(1, 0, 8'h01, 0, 3'd7, 2'd0, 2'd0, 4'h0, 4'h0, 8'hFF, "R4 rotate 7");
    // Mode 0 mixed set/reset
    drive(1, 0, 8'h3C, 0, 3'd0, 2'd0, 2'd0, 4'b0001, 4'b0101, 8'hFF, "R5 mixed planes");
    // Mode 2 nibble replicate
    drive(1, 0, 8'hFB, 0, 3'd2, 2'd0, 2'd2, 4'h0, 4'h0, 8'hFF, "R7 nibble");
    // Mode 3 fill with rotated-host mask
    drive(1, 0, 8'hF0, 0, 3'd4, 2'd0, 2'd3, 4'b1010, 4'h0, 8'h3C, "R8 fill mask");
    drive(1, 0, 8'hFF, 0, 3'd0, 2'd0, 2'd3, 4'b0110, 4'h0, 8'hFF, "R8 fill full");
    // Logic functions
    drive(1, 0, 8'h05, 0, 3'd0, 2'd1, 2'd2, 4'h0, 4'h0, 8'hFF, "R9 AND");
    drive(1, 0, 8'h05, 0, 3'd0, 2'd2, 2'd2, 4'h0, 4'h0, 8'hFF, "R9 OR");
    drive(1, 0, 8'h05, 0, 3'd0, 2'd3, 2'd2, 4'h0, 4'h0, 8'hFF, "R9 XOR");
    // Partial mask
    drive(1, 0, 8'hFF, 0, 3'd0, 2'd0, 2'd0, 4'h0, 4'h0, 8'h0F, "R10 partial mask");
    drive(1, 0, 8'h00, 0, 3'd1, 2'd2, 2'd0, 4'h0, 4'h0, 8'hA5, "R10 OR partial");
    // Zero mask COPY in modes 0, 2, 3
    drive(1, 0, 8'hFF, 0, 3'd0, 2'd0, 2'd0, 4'hF, 4'h3, 8'h00, "R11 mode0");
    drive(1, 0, 8'h0F, 0, 3'd0, 2'd0, 2'd2, 4'h0, 4'h0, 8'h00, "R11 mode2");
    drive(1, 0, 8'hFF, 0, 3'd0, 2'd0, 2'd3, 4'hF, 4'h0, 8'h00, "R11 mode3");
    // Same-cycle read and write: write sees old latch
    drive(1, 1, 8'h00, 32'h1234_5678, 3'd0, 2'd0, 2'd1, 4'h0, 4'h0, 8'h00, "R3 old latch");
    drive(1, 0, 8'h00, 0, 3'd0, 2'd0, 2'd1, 4'h0, 4'h0, 8'h00, "R3 new latch");
    drive(1, 0, 8'h0A, 0, 3'd0, 2'd3, 2'd2, 4'h0, 4'h0, 8'hF0, "R9/R10 XOR upper");
    idle(3);
    // Hold between writes
    check(outValid == 1'b0, "R2 idle valid", 32'(outValid), 32'h0);
    check(outWord == lastExp, "R2 word holds", outWord, lastExp);
    drive(0, 1, 8'h00, 32'hFFFF_0000, 0, 0, 0, 0, 0, 0, "");
    idle(2);
    check(outWord == lastExp, "R2 word holds after read", outWord, lastExp);
    check(sbQ.size() == 0, "R2 all results seen", 32'(sbQ.size()), 32'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule